// File: doc/BRIEF.md
# Daisy-chained ADC serial readout controller

This block sits on the host side of a chain of K serial ADCs that share one data line, one serial clock, one chip select and one synchronisation strobe. The device nearest the host drives the data line and the data-ready strobe. Each device shifts its own result out, followed by the results it receives from the devices further down the chain. In one data-ready window the controller therefore reads one long stream of K×24 bits and splits it into K results.

On `start_i` the controller pulses the shared synchronisation line low for a fixed number of system clocks. It then ignores the data-ready strobe for a fixed settling time. After that, every falling edge of the synchronised data-ready strobe starts a frame. The controller drives exactly K×24 serial clock periods, with the clock idle high. It samples the data line on each rising edge of the serial clock, because the ADCs change their data on the falling edge. The K words are then presented one per cycle, each tagged with its position in the chain, and a frame-done pulse follows them.

If the data-ready strobe returns high before the stream is complete, the frame is dropped and a one-cycle error pulse is raised. The chip select is either held low permanently or asserted only while bits are being clocked, as chosen by configuration.

Top module: `chain_adc_reader`

## Requirements
- R1: While reset is asserted and after it is released, `sclk_o` and `sync_no` are 1 and `res_valid_o`, `frame_done_o` and `frame_err_o` are 0. `cs_no` is 1 when `cfg_cs_active_i` is 1.
- R2: A `start_i` pulse drives `sync_no` low for exactly SYNC_CYC consecutive system clock cycles. While `sync_no` is low, `sclk_o` stays high and no result is output.
- R3: A falling edge of `drdy_ni` is ignored, with no `sclk_o` falling edge and no result, if it comes before the first `start_i`, or while `sync_no` is low, or within SETTLE_CYC cycles after `sync_no` returns high.
- R4: Once settling has ended, a falling edge of `drdy_ni` (after a two-flop synchroniser) starts a frame. The frame has exactly K×24 falling edges of `sclk_o`, and `sclk_o` is idle high outside frames. K is taken from `cfg_dev_cnt_i` at frame start: a value of 0 counts as 1, and a value above MAX_DEV counts as MAX_DEV.
- R5: `sdo_i` is sampled in the cycle in which `sclk_o` rises. The source changes it after each falling edge. Each half period of `sclk_o` lasts `cfg_sclk_div_i` system clocks, and this value must be at least 3.
- R6: A complete frame outputs K words on consecutive cycles with `res_valid_o` high. `res_idx_o` is 0 for the first 24 bits of the stream and counts up by one per word. Each word is in arrival order, so the first bit received ends up in bit 23.
- R7: `frame_done_o` pulses for one cycle, in the cycle after the last word of a complete frame.
- R8: If `drdy_ni` rises before all K×24 bits have been sampled, `frame_err_o` pulses for one cycle. That frame produces no `res_valid_o` and no `frame_done_o`.
- R9: With `cfg_cs_active_i` = 1, `cs_no` is low only while a frame is being clocked and is high otherwise. With `cfg_cs_active_i` = 0, `cs_no` is always low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_dev_cnt_i | input | CNT_W (4) | Number of devices in the chain, K |
| cfg_sclk_div_i | input | DIV_W (8) | Half period of the serial clock, in system clocks |
| cfg_cs_active_i | input | 1 | 1: chip select asserted per frame; 0: held low |
| start_i | input | 1 | Request a synchronisation pulse |
| drdy_ni | input | 1 | Data-ready strobe from the first device, asynchronous, active low |
| sdo_i | input | 1 | Serial data from the first device, asynchronous |
| sclk_o | output | 1 | Shared serial clock |
| cs_no | output | 1 | Shared chip select, active low |
| sync_no | output | 1 | Shared synchronisation strobe, active low |
| res_valid_o | output | 1 | Result word valid |
| res_data_o | output | 24 | Result word |
| res_idx_o | output | IDX_W (3) | Chain position of the result |
| frame_done_o | output | 1 | Frame complete, one-cycle pulse |
| frame_err_o | output | 1 | Short frame, one-cycle pulse |

## Verification
The assertions check these rules on every cycle: the chip select and serial clock agree in both chip-select modes, the clock stays quiet and no results appear during synchronisation, word indices start at zero and count up without gaps, and a done pulse follows directly after the last word and never comes with an error. Only the bench scenarios can show the rest. These are that the words carry the correct bits in the correct chain order for several chain lengths and clock dividers, and that the number of serial clock edges equals K×24. They also cover clamping of K, data-ready edges that are ignored before and shortly after synchronisation, and a short frame being dropped.

// File: rtl/chain_rd_pkg.sv
package chain_rd_pkg;
  localparam int unsigned WORD_W = 24;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SYNC,
    ST_SETTLE,
    ST_WAIT,
    ST_SHIFT,
    ST_EMIT,
    ST_DONE
  } rd_state_e;
endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/sclk_gen.sv
module sclk_gen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             sclk_o,
  output logic             rise_o
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q;
  logic             sclk_q;
  logic             term;

  assign term = (cnt_q == div_i - ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b1;
    end else if (!en_i) begin
      cnt_q  <= '0;
      sclk_q <= 1'b1;
    end else if (term) begin
      cnt_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt_q <= cnt_q + ONE;
    end
  end

  // idle high as soon as enable drops
  assign sclk_o = sclk_q | ~en_i;
  assign rise_o = en_i & term & ~sclk_q;
endmodule

// File: rtl/chain_deser.sv
module chain_deser #(
  parameter int unsigned MAX_DEV = 8,
  parameter int unsigned WORD_W  = 24,
  localparam int unsigned CNT_W  = $clog2(MAX_DEV + 1),
  localparam int unsigned IDX_W  = (MAX_DEV > 1) ? $clog2(MAX_DEV) : 1,
  localparam int unsigned BIT_W  = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              bit_stb_i,
  input  logic              bit_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              word_done_o,
  output logic [CNT_W-1:0]  dev_cnt_o,
  output logic [WORD_W-1:0] rd_word_o
);
  logic [WORD_W-2:0] sr_q;
  logic [BIT_W-1:0]  bit_q;
  logic [CNT_W-1:0]  dev_q;
  logic              last_bit;
  logic [WORD_W-1:0] words_q [MAX_DEV];

  assign last_bit    = (bit_q == BIT_W'(WORD_W - 1));
  assign word_done_o = bit_stb_i & last_bit;
  assign dev_cnt_o   = dev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      bit_q <= '0;
      dev_q <= '0;
    end else if (clr_i) begin
      bit_q <= '0;
      dev_q <= '0;
    end else if (bit_stb_i) begin
      sr_q <= {sr_q[WORD_W-3:0], bit_i};
      if (last_bit) begin
        bit_q <= '0;
        dev_q <= dev_q + CNT_W'(1);
      end else begin
        bit_q <= bit_q + BIT_W'(1);
      end
    end
  end

  for (genvar g = 0; g < MAX_DEV; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) words_q[g] <= '0;
      else if (word_done_o && dev_q == CNT_W'(g)) words_q[g] <= {sr_q, bit_i};
    end
  end

  assign rd_word_o = words_q[rd_idx_i];
endmodule

// File: rtl/chain_adc_reader.sv
module chain_adc_reader
  import chain_rd_pkg::*;
#(
  parameter int unsigned MAX_DEV    = 8,
  parameter int unsigned DIV_W      = 8,
  parameter int unsigned SYNC_CYC   = 8,
  parameter int unsigned SETTLE_CYC = 100,
  localparam int unsigned CNT_W     = $clog2(MAX_DEV + 1),
  localparam int unsigned IDX_W     = (MAX_DEV > 1) ? $clog2(MAX_DEV) : 1,
  localparam int unsigned TMR_W     = $clog2(SYNC_CYC + SETTLE_CYC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  cfg_dev_cnt_i,
  input  logic [DIV_W-1:0]  cfg_sclk_div_i,
  input  logic              cfg_cs_active_i,
  input  logic              start_i,
  input  logic              drdy_ni,
  input  logic              sdo_i,
  output logic              sclk_o,
  output logic              cs_no,
  output logic              sync_no,
  output logic              res_valid_o,
  output logic [WORD_W-1:0] res_data_o,
  output logic [IDX_W-1:0]  res_idx_o,
  output logic              frame_done_o,
  output logic              frame_err_o
);
  rd_state_e         state_q;
  logic [TMR_W-1:0]  tmr_q;
  logic [CNT_W-1:0]  k_q;
  logic [IDX_W-1:0]  emit_q;
  logic              drdy_s, sdo_s, drdy_q, drdy_fall;
  logic              sclk_en, rise_stb, frame_clr;
  logic              word_done, frame_full;
  logic [CNT_W-1:0]  dev_cnt;
  logic [WORD_W-1:0] rd_word;

  function automatic logic [CNT_W-1:0] clamp_k(logic [CNT_W-1:0] v);
    if (v == '0) return CNT_W'(1);
    if (v > CNT_W'(MAX_DEV)) return CNT_W'(MAX_DEV);
    return v;
  endfunction

  bit_sync #(.W(2), .RST_VAL(2'b10)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({drdy_ni, sdo_i}),
    .q_o    ({drdy_s, sdo_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drdy_q <= 1'b1;
    else         drdy_q <= drdy_s;
  end
  assign drdy_fall = drdy_q & ~drdy_s;

  assign sclk_en   = (state_q == ST_SHIFT);
  assign frame_clr = (state_q == ST_WAIT) && drdy_fall;

  sclk_gen #(.DIV_W(DIV_W)) u_sclk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (sclk_en),
    .div_i  (cfg_sclk_div_i),
    .sclk_o (sclk_o),
    .rise_o (rise_stb)
  );

  chain_deser #(.MAX_DEV(MAX_DEV), .WORD_W(WORD_W)) u_deser (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (frame_clr),
    .bit_stb_i   (rise_stb),
    .bit_i       (sdo_s),
    .rd_idx_i    (emit_q),
    .word_done_o (word_done),
    .dev_cnt_o   (dev_cnt),
    .rd_word_o   (rd_word)
  );

  assign frame_full = word_done && (dev_cnt == k_q - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      tmr_q        <= '0;
      k_q          <= CNT_W'(1);
      emit_q       <= '0;
      res_valid_o  <= 1'b0;
      res_data_o   <= '0;
      res_idx_o    <= '0;
      frame_done_o <= 1'b0;
      frame_err_o  <= 1'b0;
    end else begin
      res_valid_o  <= 1'b0;
      frame_done_o <= 1'b0;
      frame_err_o  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_SYNC;
            tmr_q   <= '0;
          end
        end
        ST_SYNC: begin
          if (tmr_q == TMR_W'(SYNC_CYC - 1)) begin
            state_q <= ST_SETTLE;
            tmr_q   <= '0;
          end else begin
            tmr_q <= tmr_q + TMR_W'(1);
          end
        end
        ST_SETTLE: begin
          if (tmr_q == TMR_W'(SETTLE_CYC - 1)) state_q <= ST_WAIT;
          else tmr_q <= tmr_q + TMR_W'(1);
        end
        ST_WAIT: begin
          if (drdy_fall) begin
            state_q <= ST_SHIFT;
            k_q     <= clamp_k(cfg_dev_cnt_i);
          end else if (start_i) begin
            state_q <= ST_SYNC;
            tmr_q   <= '0;
          end
        end
        ST_SHIFT: begin
          if (frame_full) begin
            state_q <= ST_EMIT;
            emit_q  <= '0;
          end else if (drdy_s) begin
            state_q     <= ST_WAIT;
            frame_err_o <= 1'b1;
          end
        end
        ST_EMIT: begin
          res_valid_o <= 1'b1;
          res_data_o  <= rd_word;
          res_idx_o   <= emit_q;
          if (CNT_W'(emit_q) == k_q - CNT_W'(1)) state_q <= ST_DONE;
          else emit_q <= emit_q + IDX_W'(1);
        end
        ST_DONE: begin
          frame_done_o <= 1'b1;
          state_q      <= ST_WAIT;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sync_no = (state_q != ST_SYNC);
  assign cs_no   = cfg_cs_active_i ? (state_q != ST_SHIFT) : 1'b0;
endmodule

// File: rtl/chain_adc_reader_chk.sv
module chain_adc_reader_chk #(
  parameter int unsigned IDX_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_cs_active_i,
  input logic             sclk_o,
  input logic             cs_no,
  input logic             sync_no,
  input logic             res_valid_o,
  input logic [IDX_W-1:0] res_idx_o,
  input logic             frame_done_o,
  input logic             frame_err_o
);
  p_sclk_idle_deselect_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_cs_active_i && cs_no) |-> sclk_o);

  p_cs_tied_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_cs_active_i |-> !cs_no);

  p_sync_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_no |-> (sclk_o && !res_valid_o && !frame_done_o));

  p_first_idx_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(res_valid_o) |-> (res_idx_o == '0));

  p_idx_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && $past(res_valid_o)) |-> (res_idx_o == IDX_W'($past(res_idx_o) + 1'b1)));

  p_done_after_word_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> ($past(res_valid_o) && !res_valid_o));

  p_err_alone_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |-> (!res_valid_o && !frame_done_o));
endmodule

bind chain_adc_reader chain_adc_reader_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .cfg_cs_active_i (cfg_cs_active_i),
  .sclk_o          (sclk_o),
  .cs_no           (cs_no),
  .sync_no         (sync_no),
  .res_valid_o     (res_valid_o),
  .res_idx_o       (res_idx_o),
  .frame_done_o    (frame_done_o),
  .frame_err_o     (frame_err_o)
);

// File: tb/chain_adc_reader_test.sv
module chain_adc_reader_test;
  localparam int MAX_DEV    = 8;
  localparam int SYNC_CYC   = 8;
  localparam int SETTLE_CYC = 100;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  cfg_dev_cnt_i = 4'd1;
  logic [7:0]  cfg_sclk_div_i = 8'd3;
  logic        cfg_cs_active_i = 1'b1;
  logic        start_i = 1'b0;
  logic        drdy_ni = 1'b1;
  logic        sdo_i = 1'b0;
  logic        sclk_o, cs_no, sync_no, res_valid_o, frame_done_o, frame_err_o;
  logic [23:0] res_data_o;
  logic [2:0]  res_idx_o;

  int nvec = 0, nfail = 0;
  int fall_cnt = 0, done_cnt = 0, err_cnt = 0, sync_run = 0, cyc = 0;
  bit          bitq[$];
  logic [26:0] expq[$];

  chain_adc_reader #(.MAX_DEV(MAX_DEV), .SYNC_CYC(SYNC_CYC), .SETTLE_CYC(SETTLE_CYC)) uut (.*);

  always #5 clk_i = ~clk_i;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // chain model: a new bit appears after every serial clock fall
  always @(negedge sclk_o) begin
    fall_cnt++;
    if (bitq.size() > 0) sdo_i <= bitq.pop_front();
  end

  // reference comparison every clock
  always @(negedge clk_i) begin
    cyc++;
    if (rst_ni) begin
      if (res_valid_o) begin
        if (expq.size() == 0) check(0, "R8 unexpected word", {res_idx_o, res_data_o}, 0);
        else begin
          logic [26:0] e;
          e = expq.pop_front();
          check({res_idx_o, res_data_o} == e, "R6 word/index", {res_idx_o, res_data_o}, e);
        end
      end
      if (frame_done_o) done_cnt++;
      if (frame_err_o) err_cnt++;
      if (!cfg_cs_active_i && cs_no) check(0, "R9 cs tied low", cs_no, 0);
      if (!sync_no) sync_run++;
      else if (sync_run > 0) begin
        check(sync_run == SYNC_CYC, "R2 sync width", sync_run, SYNC_CYC);
        sync_run = 0;
      end
    end
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      if (cyc > 150000) begin
        nfail++;
        $display("FAIL watchdog: actual %0d expected <150000", cyc);
        summary();
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic do_sync();
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
    wait_cyc(SYNC_CYC + SETTLE_CYC + 10);
  endtask

  task automatic do_frame(input int cfgk, input int k, input int div, input bit csact);
    int d0, e0, n;
    cfg_dev_cnt_i = 4'(cfgk);
    cfg_sclk_div_i = 8'(div);
    cfg_cs_active_i = csact;
    for (int i = 0; i < k; i++) begin
      logic [23:0] w;
      w = (i == 0) ? 24'h800001 : 24'($urandom);
      expq.push_back({3'(i), w});
      for (int b = 23; b >= 0; b--) bitq.push_back(w[b]);
    end
    fall_cnt = 0; d0 = done_cnt; e0 = err_cnt; n = 0;
    wait_cyc(2);
    drdy_ni = 1'b0;
    wait_cyc(20);
    check(cs_no == 1'b0, "R9 cs low in frame", cs_no, 0);
    while (done_cnt == d0 && err_cnt == e0 && n < 8000) begin
      wait_cyc(1); n++;
    end
    check(done_cnt == d0 + 1, "R7 frame done", done_cnt - d0, 1);
    check(err_cnt == e0, "R8 no error on full frame", err_cnt - e0, 0);
    check(fall_cnt == k * 24, "R4 falling edge count", fall_cnt, k * 24);
    check(expq.size() == 0, "R6 all words out", expq.size(), 0);
    check(sclk_o == 1'b1, "R4 sclk idle high", sclk_o, 1);
    check(cs_no == csact, "R9 cs after frame", cs_no, csact);
    drdy_ni = 1'b1;
    bitq.delete();
    expq.delete();
    wait_cyc(10);
  endtask

  initial begin
    wait_cyc(3);
    check(sclk_o && sync_no && cs_no && !res_valid_o && !frame_done_o && !frame_err_o,
          "R1 in reset", {sclk_o, sync_no, cs_no, res_valid_o, frame_done_o, frame_err_o}, 6'b111000);
    rst_ni = 1'b1;
    wait_cyc(2);
    check(sclk_o && sync_no && cs_no && !res_valid_o && !frame_done_o && !frame_err_o,
          "R1 after reset", {sclk_o, sync_no, cs_no, res_valid_o, frame_done_o, frame_err_o}, 6'b111000);

    // R3: data-ready before any sync is ignored
    fall_cnt = 0;
    drdy_ni = 1'b0; wait_cyc(60); drdy_ni = 1'b1; wait_cyc(10);
    check(fall_cnt == 0, "R3 ignored before sync", fall_cnt, 0);

    // R3: data-ready during settling is ignored
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
    wait_cyc(SYNC_CYC + 20);
    drdy_ni = 1'b0; wait_cyc(40); drdy_ni = 1'b1;
    wait_cyc(SETTLE_CYC);
    check(fall_cnt == 0 && done_cnt == 0 && err_cnt == 0, "R3 ignored while settling",
          fall_cnt + done_cnt + err_cnt, 0);

    do_frame(1, 1, 3, 1'b1);            // R4 R5 R6 single device
    do_frame(4, 4, 3, 1'b1);            // R6 four devices
    do_frame(3, 3, 5, 1'b0);            // R5 R9 slower clock, cs tied low
    do_frame(0, 1, 4, 1'b1);            // R4 clamp 0 -> 1
    do_frame(12, 8, 3, 1'b1);           // R4 clamp above max
    do_frame(8, 8, 7, 1'b0);            // R5 full chain, slow clock

    // R8: short frame
    begin
      int e0, d0;
      e0 = err_cnt; d0 = done_cnt;
      cfg_dev_cnt_i = 4'd3; cfg_sclk_div_i = 8'd4; cfg_cs_active_i = 1'b1;
      for (int i = 0; i < 72; i++) bitq.push_back(i[0]);
      fall_cnt = 0;
      drdy_ni = 1'b0; wait_cyc(150); drdy_ni = 1'b1; wait_cyc(12);
      check(err_cnt == e0 + 1, "R8 short frame error", err_cnt - e0, 1);
      check(done_cnt == d0, "R8 no done on short frame", done_cnt - d0, 0);
      check(fall_cnt < 72, "R8 clocking stopped", fall_cnt, 72);
      check(cs_no == 1'b1 && sclk_o == 1'b1, "R9 idle after short frame", {cs_no, sclk_o}, 2'b11);
      bitq.delete();
      wait_cyc(10);
    end

    // resync from waiting state, then a normal frame
    do_sync();
    do_frame(2, 2, 3, 1'b1);

    summary();
  end
endmodule